// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a general-purpose pin port that a processor controls over a simple word-wide register bus. Each pin has an output value, an output-enable bit, an interrupt enable bit and an edge-capture flag. The port drives a single level interrupt line toward an interrupt controller. The number of pins is set by a parameter. Every register keeps one bit per pin, and bits above the pin count read as zero.

Pin inputs pass through a two-stage synchronizer. The synchronized level is what a data read returns and what the edge detector sees. An edge is a difference between the synchronized level and its value one clock earlier. The trigger style is fixed at elaboration and cannot be changed by software. It selects whether rising edges, falling edges or both set the capture flags, or whether the interrupt follows the pin levels directly.

A small bus state machine answers reads. It has two states. In BUS_IDLE no response is being presented. A read request moves it to BUS_RESP, where `bus_rvalid` is high and the read word is on `bus_rdata`. From BUS_RESP, another read request in the same cycle keeps it in BUS_RESP, and any other cycle returns it to BUS_IDLE. Writes complete in the cycle they are presented and do not change the state.

Top module: `pio_port`

## Requirements
- R1: After reset, `pin_out`, `pin_oe` and `irq` are all zero, and the direction, mask and capture registers read zero.
- R2: The direction register sits at byte offset 0x4. A 1 in bit i drives `pin_oe[i]` high (pin i is an output), a 0 makes pin i an input, and a read returns the stored bits.
- R3: A write to byte offset 0x0 sets `pin_out`. A read of offset 0x0 returns the pin input levels as they stood two clocks earlier (after the synchronizer), not the written value.
- R4: The interrupt mask sits at byte offset 0x8. A 1 in bit i enables pin i's interrupt. A read returns the stored bits, and bits at or above the pin count read zero.
- R5: With trigger style rising (code 0), a 0-to-1 change on a pin sets its capture bit and a 1-to-0 change does not.
- R6: With trigger style falling (code 1), a 1-to-0 change sets the capture bit and a 0-to-1 change does not.
- R7: With trigger style both (code 2), either change sets the capture bit.
- R8: The capture register sits at byte offset 0xC. Writing 1 to bit i clears it, and writing 0 leaves it unchanged.
- R9: When an edge and a clearing write reach the same capture bit in the same cycle, the bit ends up set.
- R10: In the three edge styles, `irq` is high exactly while some bit is set in both the capture register and the mask.
- R11: With trigger style level-high (code 3), `irq` is high while some masked pin's synchronized input is 1, and the capture register stays zero.
- R12: An access whose byte address has nonzero bits [1:0] is reserved. Writes to it change no register, and reads of it return zero.
- R13: `bus_rvalid` is high in the cycle after a cycle with `bus_rd` high, and low otherwise. `bus_rdata` carries the addressed word in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid |
| pin_in | input | NPINS | Pin input levels, asynchronous |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables, 1 = drive |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds four copies with 8 pins, one for each trigger style, and drives all four with the same bus traffic and pin waveform. With this arrangement a single stimulus shows how the styles differ. A falling transition sets a flag in one copy and not in another. The level copy raises its interrupt while its capture register stays empty. A clearing write timed to land on the same clock as a new rising edge leaves the flag set in the rising and both-edge copies and cleared in the falling copy. The 8-pin width also lets the bench show that bits above the pin count read back as zero.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pio_edge_cap.sv
module pio_edge_cap
    import pio_pkg::*;
#(
    parameter int    W    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cap,
    output logic [W-1:0] edge_hit
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    generate
        if (TRIG == TRIG_RISE) begin : g_rise
            assign edge_hit = rise;
        end else if (TRIG == TRIG_FALL) begin : g_fall
            assign edge_hit = fall;
        end else if (TRIG == TRIG_BOTH) begin : g_both
            assign edge_hit = rise | fall;
        end else begin : g_level
            assign edge_hit = '0;
        end
    endgenerate

    // A new edge takes priority over a clearing write to the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) cap <= '0;
        else        cap <= (cap & ~clr) | edge_hit;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_chk
            p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                edge_hit[i] |=> cap[i]);
            p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !edge_hit[i]) |=> !cap[i]);
            p_zero_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr[i] && cap[i]) |=> cap[i]);
        end
    endgenerate
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic [NPINS-1:0]  cap,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  mask_q,
    output logic [NPINS-1:0]  cap_clr
);
    bus_state_e   state_q, state_d;
    reg_sel_e     sel;
    logic         word_ok;
    logic         wr_hit;
    logic [BUS_W-1:0] rd_mux;
    logic [BUS_W-1:0] rdata_q;

    assign word_ok = (bus_addr[1:0] == 2'b00);
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign wr_hit  = bus_wr && word_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = bus_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = bus_rd ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Read multiplexer, zero-extended to bus width
    always_comb begin
        rd_mux = '0;
        if (word_ok) begin
            unique case (sel)
                SEL_DATA: rd_mux[NPINS-1:0] = pin_lvl;
                SEL_DIR:  rd_mux[NPINS-1:0] = dir_q;
                SEL_MASK: rd_mux[NPINS-1:0] = mask_q;
                SEL_CAP:  rd_mux[NPINS-1:0] = cap;
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr_hit) begin
            unique case (sel)
                SEL_DATA: data_q <= bus_wdata[NPINS-1:0];
                SEL_DIR:  dir_q  <= bus_wdata[NPINS-1:0];
                SEL_MASK: mask_q <= bus_wdata[NPINS-1:0];
                default:  ;
            endcase
        end
    end

    // Output process
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            BUS_IDLE: begin
                bus_rvalid = 1'b0;
                bus_rdata  = '0;
            end
            BUS_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            default: ;
        endcase
        cap_clr = (wr_hit && sel == SEL_CAP) ? bus_wdata[NPINS-1:0] : '0;
    end

    p_rvalid_follows_rd_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    p_no_stray_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    p_reserved_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));
    p_reserved_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] != 2'b00) |=>
            ($stable(data_q) && $stable(dir_q) && $stable(mask_q)));
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int    NPINS = 32,
    parameter trig_e TRIG  = TRIG_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int SYNC_STAGES = 2;

    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] cap;
    logic [NPINS-1:0] edge_hit;
    logic [NPINS-1:0] cap_clr;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] mask_q;

    pio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    pio_edge_cap #(.W(NPINS), .TRIG(TRIG)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .clr      (cap_clr),
        .cap      (cap),
        .edge_hit (edge_hit)
    );

    pio_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .pin_lvl    (lvl),
        .cap        (cap),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .data_q     (data_q),
        .dir_q      (dir_q),
        .mask_q     (mask_q),
        .cap_clr    (cap_clr)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    generate
        if (TRIG == TRIG_LEVEL) begin : g_irq_level
            assign irq = |(lvl & mask_q);
        end else begin : g_irq_edge
            assign irq = |(cap & mask_q);
        end
    endgenerate

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h4) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h0) |=> (pin_out == $past(bus_wdata[NPINS-1:0])));
endmodule

// File: tb/pio_port_tb.sv
`timescale 1ns/1ps
module pio_port_tb;
    import pio_pkg::*;

    localparam int NP = 8;
    localparam int NM = 4;

    typedef struct {
        logic [NM-1:0][31:0] exp;
        string               tag;
    } sb_item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [NP-1:0]  pins = '0;

    logic [31:0]    rdat  [NM];
    logic           rval  [NM];
    logic [NP-1:0]  pout  [NM];
    logic [NP-1:0]  poe   [NM];
    logic           irqs  [NM];

    int checks = 0;
    int errors = 0;
    sb_item_t sb_q[$];

    logic [NP-1:0] cur_pins = '0;
    logic [NP-1:0] mask_m = '0;
    logic [NP-1:0] mcap [NM];

    always #2.5 clk = ~clk;

    genvar g;
    generate
        for (g = 0; g < NM; g++) begin : gen_mode
            pio_port #(.NPINS(NP), .TRIG(trig_e'(g))) u_dut (
                .clk        (clk),
                .rst_n      (rst_n),
                .bus_addr   (bus_addr),
                .bus_wr     (bus_wr),
                .bus_rd     (bus_rd),
                .bus_wdata  (bus_wdata),
                .bus_rdata  (rdat[g]),
                .bus_rvalid (rval[g]),
                .pin_in     (pins),
                .pin_out    (pout[g]),
                .pin_oe     (poe[g]),
                .irq        (irqs[g])
            );
        end
    endgenerate

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor (R13: a response appears only for a pending read)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < NM; m++) begin
                if (rval[m] !== rval[0]) chk({31'd0, rval[m]}, {31'd0, rval[0]}, "R13 rvalid agreement");
            end
            if (rval[0]) begin
                if (sb_q.size() == 0) begin
                    chk(32'd1, 32'd0, "R13 response without read");
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    for (int m = 0; m < NM; m++)
                        chk(rdat[m], it.exp[m], $sformatf("%s mode%0d", it.tag, m));
                end
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [NM-1:0][31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [NM-1:0][31:0] all4(input logic [31:0] v);
        return {v, v, v, v};
    endfunction

    function automatic logic [NM-1:0][31:0] caps4();
        logic [NM-1:0][31:0] r;
        for (int m = 0; m < NM; m++) r[m] = {24'd0, mcap[m]};
        return r;
    endfunction

    task automatic cap_write(input logic [NP-1:0] v);
        bus_write(4'hC, {24'd0, v});
        for (int m = 0; m < NM; m++) mcap[m] &= ~v;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        logic [NP-1:0] r, f;
        r = v & ~cur_pins;
        f = ~v & cur_pins;
        mcap[0] |= r;
        mcap[1] |= f;
        mcap[2] |= r | f;
        cur_pins = v;
        @(negedge clk);
        pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_irqs(input string tag);
        @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            logic e;
            e = (m == 3) ? |(cur_pins & mask_m) : |(mcap[m] & mask_m);
            chk({31'd0, irqs[m]}, {31'd0, e}, $sformatf("%s irq mode%0d", tag, m));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int m = 0; m < NM; m++) mcap[m] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int m = 0; m < NM; m++) begin
            chk({24'd0, pout[m]}, 32'd0, "R1 pin_out reset");
            chk({24'd0, poe[m]},  32'd0, "R1 pin_oe reset");
            chk({31'd0, irqs[m]}, 32'd0, "R1 irq reset");
        end
        bus_read(4'h4, all4(0), "R1 dir reset");
        bus_read(4'h8, all4(0), "R1 mask reset");
        bus_read(4'hC, all4(0), "R1 cap reset");

        // R2: direction
        bus_write(4'h4, 32'h0000_00A5);
        @(negedge clk);
        chk({24'd0, poe[0]}, 32'hA5, "R2 pin_oe drive");
        bus_read(4'h4, all4(32'hA5), "R2 dir readback");

        // R3: data out and pin readback
        bus_write(4'h0, 32'h0000_003C);
        @(negedge clk);
        chk({24'd0, pout[0]}, 32'h3C, "R3 pin_out");
        set_pins(8'h5A);
        bus_read(4'h0, all4(32'h5A), "R3 data read is pin level");

        // R4: mask, upper bits read zero
        bus_write(4'h8, 32'hFFFF_FFFF);
        mask_m = 8'hFF;
        bus_read(4'h8, all4(32'hFF), "R4 mask readback");
        bus_write(4'h8, 32'h0);
        mask_m = '0;
        bus_read(4'h8, all4(0), "R4 mask cleared");

        // R5 R6 R7 R11: capture per style after earlier and new changes
        set_pins(8'h0F);
        bus_read(4'hC, caps4(), "R5 R6 R7 R11 capture by style");
        check_irqs("R10 masked off");

        // R10 R11: enable one pin's interrupt
        bus_write(4'h8, 32'h01);
        mask_m = 8'h01;
        check_irqs("R10 R11 mask bit0");
        bus_write(4'h8, 32'h10);
        mask_m = 8'h10;
        check_irqs("R10 R11 mask bit4");

        // R8: write-one-to-clear, zeros keep
        cap_write(8'h0F);
        bus_read(4'hC, caps4(), "R8 partial clear");
        check_irqs("R10 after partial clear");
        cap_write(8'hFF);
        bus_read(4'hC, all4(0), "R8 full clear");
        check_irqs("R10 after full clear");

        // R12: reserved offsets
        bus_write(4'h1, 32'hFFFF_FFFF);
        bus_write(4'h6, 32'hFFFF_FFFF);
        bus_write(4'hA, 32'hFFFF_FFFF);
        bus_write(4'hF, 32'hFFFF_FFFF);
        @(negedge clk);
        chk({24'd0, pout[0]}, 32'h3C, "R12 pin_out untouched");
        chk({24'd0, poe[0]},  32'hA5, "R12 pin_oe untouched");
        bus_read(4'h8, all4({24'd0, mask_m}), "R12 mask untouched");
        bus_read(4'hC, caps4(), "R12 capture untouched");
        bus_read(4'h9, all4(0), "R12 reserved read zero");
        bus_read(4'h3, all4(0), "R12 reserved read zero low");

        // R13: back-to-back reads
        @(negedge clk);
        bus_addr = 4'h4; bus_rd = 1'b1;
        begin
            sb_item_t it;
            it.exp = all4(32'hA5); it.tag = "R13 back-to-back first";
            sb_q.push_back(it);
        end
        @(negedge clk);
        bus_addr = 4'h8;
        begin
            sb_item_t it;
            it.exp = all4({24'd0, mask_m}); it.tag = "R13 back-to-back second";
            sb_q.push_back(it);
        end
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);

        // R9: edge and clear on the same clock
        set_pins(8'h00);
        cap_write(8'hFF);
        set_pins(8'h02);
        set_pins(8'h00);
        bus_read(4'hC, caps4(), "R9 setup capture");
        @(negedge clk);
        pins = 8'h02;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'hC; bus_wdata = 32'h02; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        cur_pins = 8'h02;
        mcap[0] = 8'h02;
        mcap[1] = 8'h00;
        mcap[2] = 8'h02;
        bus_read(4'hC, caps4(), "R9 edge beats clear");

        // R11: level-high interrupt follows pin
        cap_write(8'hFF);
        bus_write(4'h8, 32'h80);
        mask_m = 8'h80;
        set_pins(8'h80);
        check_irqs("R11 level high");
        set_pins(8'h00);
        check_irqs("R11 level low");
        bus_read(4'hC, caps4(), "R11 capture after level test");

        repeat (4) @(negedge clk);
        chk(sb_q.size(), 32'd0, "R13 all reads answered");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule